// File: doc/BRIEF.md
# Launch-Time Page Ownership Walker

This block installs the per-page access rights of a virtual machine into a hardware-only protection table when that machine is started or its memory mapping is replaced. A command starts a walk over a stream of guest-page to machine-page pairs. For each pair the walker reads the current table entry for the machine page and fetches the customer's requested protection for the guest page. If the page is free, it writes the resulting owned state back into the table.

The update is all-or-nothing. When a machine page is already owned, or an entry kind is illegal, the walker marks the command as failed and consumes the rest of the stream. It then asks the stream source to rewind and replays the stream, clearing every entry it wrote earlier in the command. No undo storage is needed. A remap command also carries release entries for pages the machine no longer uses. These are applied in a second replayed pass, and only after every new page has been claimed. On completion the block pulses done, reports the outcome and the index of the failing pair, and flags whether the table was modified so that cached translations can be flushed.

Top module: `page_assign_walker`

## Requirements
- R1: A table entry whose two upper bits are 00 is free and may be claimed. Any other value makes a claim fail with error cause 0 (conflict), and that entry is left unchanged.
- R2: Pair kind 0 (guest page) with a present request writes {2'b11, code}. In the code, bit 0 denies hypervisor access and bit 1 denies DMA access.
- R3: A guest page with no present request is written 4'b1111. Pair kind 1 (a page holding the new mapping) is always written 4'b1111.
- R4: On a failed command, every entry written earlier in the command is back at 4'b0000 and all other entries are untouched. err_idx_o gives the zero-based index of the failing pair.
- R5: Rollback pulses map_rewind_o for one cycle after the whole stream has been consumed. The source then replays it from pair 0. A failure at pair 0 completes with no rewind.
- R6: In a remap command, pairs of kind 2 (release) write 4'b0000 only in a second pass after a rewind, once all claims have succeeded. A failed remap releases nothing.
- R7: Kind 2 in a launch command, or kind 3 in any command, fails with error cause 1 (bad kind).
- R8: done_o is a one-cycle pulse per command. err_o is high only together with done_o. cmd_ready_o is high only while no command is in progress.
- R9: flush_o pulses with done_o exactly when at least one table write happened during the command.
- R10: After reset the block is idle: cmd_ready_o high, and done_o, map_ready_o, map_rewind_o and tbl_we_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_remap_i | input | 1 | 1 = remap, 0 = launch |
| cmd_ready_o | output | 1 | Idle, command accepted |
| map_valid_i | input | 1 | Pair valid |
| map_ready_o | output | 1 | Pair accepted |
| map_gpn_i | input | GPN_W | Guest page number |
| map_mpn_i | input | MPN_W | Machine page number |
| map_kind_i | input | 2 | 0 guest, 1 mapping page, 2 release, 3 reserved |
| map_last_i | input | 1 | Final pair of the stream |
| map_rewind_o | output | 1 | Restart stream from pair 0 |
| prot_gpn_o | output | GPN_W | Requested-protection lookup address |
| prot_present_i | input | 1 | Lookup hit |
| prot_code_i | input | 2 | Requested deny code |
| tbl_rd_o | output | 1 | Table read, data one cycle later |
| tbl_we_o | output | 1 | Table write |
| tbl_addr_o | output | MPN_W | Table address |
| tbl_wdata_o | output | 4 | Table write data |
| tbl_rdata_i | input | 4 | Table read data |
| done_o | output | 1 | Command complete pulse |
| err_o | output | 1 | Command failed, with done_o |
| err_cause_o | output | 1 | 0 conflict, 1 bad kind |
| err_idx_o | output | IDX_W | Index of failing pair |
| flush_o | output | 1 | Table modified, with done_o |

## Verification
The hardest case to reach from the ports is a failure in the middle of a stream, after earlier pairs have already been written. The same applies to a failing remap whose release pairs sit before the conflict. Both need pages owned in advance and a source that honours the rewind. The bench gets there in three ways: it runs earlier launches that leave owned pages behind, it preloads its own table model with chosen entry values, and it uses a stream driver that restarts on every rewind pulse. Each table entry is then compared against values derived from the requirements.

// File: rtl/paw_pkg.sv
package paw_pkg;
  localparam int ENT_W = 4;
  localparam logic [1:0] KIND_GUEST   = 2'd0;
  localparam logic [1:0] KIND_TABLE   = 2'd1;
  localparam logic [1:0] KIND_RELEASE = 2'd2;
  localparam logic       CAUSE_CONFLICT = 1'b0;
  localparam logic       CAUSE_BADKIND  = 1'b1;
  localparam logic [ENT_W-1:0] ENT_FREE = 4'b0000;
  localparam logic [ENT_W-1:0] ENT_PRIV = 4'b1111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_DRAIN,
    ST_REWIND,
    ST_UNDO,
    ST_RELEASE
  } walk_st_e;
endpackage

// File: rtl/paw_eval.sv
module paw_eval
  import paw_pkg::*;
(
  input  logic [1:0]       kind_i,
  input  logic             remap_i,
  input  logic [ENT_W-1:0] old_i,
  input  logic             present_i,
  input  logic [1:0]       code_i,
  output logic             err_o,
  output logic             cause_o,
  output logic             we_o,
  output logic [ENT_W-1:0] wdata_o
);
  logic owned;
  assign owned = (old_i[3:2] != 2'b00);

  always_comb begin
    err_o   = 1'b0;
    cause_o = CAUSE_CONFLICT;
    we_o    = 1'b0;
    wdata_o = ENT_PRIV;
    unique case (kind_i)
      KIND_GUEST, KIND_TABLE: begin
        if (owned) begin
          err_o = 1'b1;
        end else begin
          we_o = 1'b1;
          if (kind_i == KIND_GUEST && present_i) wdata_o = {2'b11, code_i};
        end
      end
      KIND_RELEASE: begin
        // releases are deferred to the second pass of a remap
        if (!remap_i) begin
          err_o   = 1'b1;
          cause_o = CAUSE_BADKIND;
        end
      end
      default: begin
        err_o   = 1'b1;
        cause_o = CAUSE_BADKIND;
      end
    endcase
  end
endmodule

// File: rtl/paw_ctrl.sv
module paw_ctrl
  import paw_pkg::*;
#(
  parameter int GPN_W = 20,
  parameter int MPN_W = 24,
  parameter int IDX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic             cmd_remap_i,
  output logic             cmd_ready_o,
  input  logic             map_valid_i,
  output logic             map_ready_o,
  input  logic [GPN_W-1:0] map_gpn_i,
  input  logic [MPN_W-1:0] map_mpn_i,
  input  logic [1:0]       map_kind_i,
  input  logic             map_last_i,
  output logic             map_rewind_o,
  output logic [GPN_W-1:0] prot_gpn_o,
  input  logic             prot_present_i,
  input  logic [1:0]       prot_code_i,
  output logic             tbl_rd_o,
  output logic             tbl_we_o,
  output logic [MPN_W-1:0] tbl_addr_o,
  output logic [ENT_W-1:0] tbl_wdata_o,
  input  logic [ENT_W-1:0] tbl_rdata_i,
  output logic             fin_o,
  output logic             fin_err_o,
  output logic             fin_cause_o,
  output logic [IDX_W-1:0] fin_idx_o,
  output logic             fin_flush_o
);
  walk_st_e         st_q, st_d;
  logic             remap_q;
  logic [GPN_W-1:0] gpn_q;
  logic [MPN_W-1:0] mpn_q;
  logic [1:0]       kind_q;
  logic             last_q;
  logic [IDX_W-1:0] idx_q, err_idx_q;
  logic             failed_q, cause_q, wrote_q;

  logic             hs;
  logic             ev_err, ev_cause, ev_we;
  logic [ENT_W-1:0] ev_wdata;
  logic             undo_hit;

  paw_eval u_eval (
    .kind_i   (kind_q),
    .remap_i  (remap_q),
    .old_i    (tbl_rdata_i),
    .present_i(prot_present_i),
    .code_i   (prot_code_i),
    .err_o    (ev_err),
    .cause_o  (ev_cause),
    .we_o     (ev_we),
    .wdata_o  (ev_wdata)
  );

  assign cmd_ready_o  = (st_q == ST_IDLE);
  assign map_ready_o  = (st_q == ST_FETCH) || (st_q == ST_DRAIN) ||
                        (st_q == ST_UNDO)  || (st_q == ST_RELEASE);
  assign hs           = map_valid_i && map_ready_o;
  assign map_rewind_o = (st_q == ST_REWIND);
  assign prot_gpn_o   = gpn_q;
  assign tbl_rd_o     = (st_q == ST_FETCH) && hs;
  assign undo_hit     = (idx_q < err_idx_q) &&
                        ((map_kind_i == KIND_GUEST) || (map_kind_i == KIND_TABLE));

  always_comb begin
    tbl_we_o    = 1'b0;
    tbl_addr_o  = map_mpn_i;
    tbl_wdata_o = ENT_FREE;
    unique case (st_q)
      ST_CHECK: begin
        tbl_we_o    = ev_we && !ev_err;
        tbl_addr_o  = mpn_q;
        tbl_wdata_o = ev_wdata;
      end
      ST_UNDO:    tbl_we_o = hs && undo_hit;
      ST_RELEASE: tbl_we_o = hs && (map_kind_i == KIND_RELEASE);
      default: ;
    endcase
  end

  always_comb begin
    st_d  = st_q;
    fin_o = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (cmd_valid_i) st_d = ST_FETCH;
      ST_FETCH: if (hs) st_d = ST_CHECK;
      ST_CHECK: begin
        if (ev_err) begin
          if (!last_q) st_d = ST_DRAIN;
          else if (idx_q == '0) begin
            st_d  = ST_IDLE;
            fin_o = 1'b1;
          end else st_d = ST_REWIND;
        end else if (last_q) begin
          if (remap_q) st_d = ST_REWIND;
          else begin
            st_d  = ST_IDLE;
            fin_o = 1'b1;
          end
        end else st_d = ST_FETCH;
      end
      ST_DRAIN: begin
        if (hs && map_last_i) begin
          if (err_idx_q == '0) begin
            st_d  = ST_IDLE;
            fin_o = 1'b1;
          end else st_d = ST_REWIND;
        end
      end
      ST_REWIND: st_d = failed_q ? ST_UNDO : ST_RELEASE;
      ST_UNDO, ST_RELEASE: begin
        if (hs && map_last_i) begin
          st_d  = ST_IDLE;
          fin_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign fin_err_o   = failed_q || ((st_q == ST_CHECK) && ev_err);
  assign fin_cause_o = ((st_q == ST_CHECK) && ev_err) ? ev_cause : cause_q;
  assign fin_idx_o   = ((st_q == ST_CHECK) && ev_err) ? idx_q : err_idx_q;
  assign fin_flush_o = wrote_q || tbl_we_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      remap_q   <= 1'b0;
      gpn_q     <= '0;
      mpn_q     <= '0;
      kind_q    <= KIND_GUEST;
      last_q    <= 1'b0;
      idx_q     <= '0;
      err_idx_q <= '0;
      failed_q  <= 1'b0;
      cause_q   <= CAUSE_CONFLICT;
      wrote_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (tbl_we_o) wrote_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_valid_i) begin
            remap_q   <= cmd_remap_i;
            idx_q     <= '0;
            err_idx_q <= '0;
            failed_q  <= 1'b0;
            wrote_q   <= 1'b0;
          end
        end
        ST_FETCH: begin
          if (hs) begin
            gpn_q  <= map_gpn_i;
            mpn_q  <= map_mpn_i;
            kind_q <= map_kind_i;
            last_q <= map_last_i;
          end
        end
        ST_CHECK: begin
          if (ev_err) begin
            failed_q  <= 1'b1;
            cause_q   <= ev_cause;
            err_idx_q <= idx_q;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_REWIND: idx_q <= '0;
        ST_UNDO:   if (hs) idx_q <= idx_q + 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/paw_status.sv
module paw_status #(
  parameter int IDX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fin_i,
  input  logic             fin_err_i,
  input  logic             fin_cause_i,
  input  logic [IDX_W-1:0] fin_idx_i,
  input  logic             fin_flush_i,
  output logic             done_o,
  output logic             err_o,
  output logic             err_cause_o,
  output logic [IDX_W-1:0] err_idx_o,
  output logic             flush_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      err_cause_o <= 1'b0;
      err_idx_o   <= '0;
      flush_o     <= 1'b0;
    end else begin
      done_o  <= fin_i;
      err_o   <= fin_i && fin_err_i;
      flush_o <= fin_i && fin_flush_i;
      if (fin_i) begin
        err_cause_o <= fin_cause_i;
        err_idx_o   <= fin_err_i ? fin_idx_i : '0;
      end
    end
  end
endmodule

// File: rtl/page_assign_walker.sv
module page_assign_walker #(
  parameter int GPN_W = 20,
  parameter int MPN_W = 24,
  parameter int IDX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic             cmd_remap_i,
  output logic             cmd_ready_o,
  input  logic             map_valid_i,
  output logic             map_ready_o,
  input  logic [GPN_W-1:0] map_gpn_i,
  input  logic [MPN_W-1:0] map_mpn_i,
  input  logic [1:0]       map_kind_i,
  input  logic             map_last_i,
  output logic             map_rewind_o,
  output logic [GPN_W-1:0] prot_gpn_o,
  input  logic             prot_present_i,
  input  logic [1:0]       prot_code_i,
  output logic             tbl_rd_o,
  output logic             tbl_we_o,
  output logic [MPN_W-1:0] tbl_addr_o,
  output logic [3:0]       tbl_wdata_o,
  input  logic [3:0]       tbl_rdata_i,
  output logic             done_o,
  output logic             err_o,
  output logic             err_cause_o,
  output logic [IDX_W-1:0] err_idx_o,
  output logic             flush_o
);
  logic             fin, fin_err, fin_cause, fin_flush;
  logic [IDX_W-1:0] fin_idx;

  paw_ctrl #(.GPN_W(GPN_W), .MPN_W(MPN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_remap_i   (cmd_remap_i),
    .cmd_ready_o   (cmd_ready_o),
    .map_valid_i   (map_valid_i),
    .map_ready_o   (map_ready_o),
    .map_gpn_i     (map_gpn_i),
    .map_mpn_i     (map_mpn_i),
    .map_kind_i    (map_kind_i),
    .map_last_i    (map_last_i),
    .map_rewind_o  (map_rewind_o),
    .prot_gpn_o    (prot_gpn_o),
    .prot_present_i(prot_present_i),
    .prot_code_i   (prot_code_i),
    .tbl_rd_o      (tbl_rd_o),
    .tbl_we_o      (tbl_we_o),
    .tbl_addr_o    (tbl_addr_o),
    .tbl_wdata_o   (tbl_wdata_o),
    .tbl_rdata_i   (tbl_rdata_i),
    .fin_o         (fin),
    .fin_err_o     (fin_err),
    .fin_cause_o   (fin_cause),
    .fin_idx_o     (fin_idx),
    .fin_flush_o   (fin_flush)
  );

  paw_status #(.IDX_W(IDX_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fin_i      (fin),
    .fin_err_i  (fin_err),
    .fin_cause_i(fin_cause),
    .fin_idx_i  (fin_idx),
    .fin_flush_i(fin_flush),
    .done_o     (done_o),
    .err_o      (err_o),
    .err_cause_o(err_cause_o),
    .err_idx_o  (err_idx_o),
    .flush_o    (flush_o)
  );
endmodule

// File: rtl/paw_chk.sv
module paw_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_ready_o,
  input logic       map_ready_o,
  input logic       map_rewind_o,
  input logic       tbl_rd_o,
  input logic       tbl_we_o,
  input logic [3:0] tbl_wdata_o,
  input logic       done_o,
  input logic       err_o,
  input logic       flush_o
);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  assert_flush_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> done_o);
  assert_rewind_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_rewind_o |=> (!map_rewind_o && !done_o));
  assert_wdata_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_o |-> (tbl_wdata_o == 4'b0000 || tbl_wdata_o[3:2] == 2'b11));
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (!map_ready_o && !tbl_we_o && !map_rewind_o));
  assert_port_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tbl_rd_o && tbl_we_o));
endmodule

bind page_assign_walker paw_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_ready_o (cmd_ready_o),
  .map_ready_o (map_ready_o),
  .map_rewind_o(map_rewind_o),
  .tbl_rd_o    (tbl_rd_o),
  .tbl_we_o    (tbl_we_o),
  .tbl_wdata_o (tbl_wdata_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .flush_o     (flush_o)
);

// File: tb/page_assign_walker_tb_top.sv
module page_assign_walker_tb_top;
  localparam int GPN_W = 6;
  localparam int MPN_W = 6;
  localparam int IDX_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             cmd_valid = 1'b0, cmd_remap = 1'b0, cmd_ready;
  logic             map_valid = 1'b0, map_ready, map_last = 1'b0, map_rewind;
  logic [GPN_W-1:0] map_gpn = '0, prot_gpn;
  logic [MPN_W-1:0] map_mpn = '0, tbl_addr;
  logic [1:0]       map_kind = 2'd0, prot_code;
  logic             prot_present, tbl_rd, tbl_we;
  logic [3:0]       tbl_wdata, tbl_rdata;
  logic             done, err, err_cause, flush;
  logic [IDX_W-1:0] err_idx;

  logic [3:0] mem [64];
  logic       req_present [64];
  logic [1:0] req_code [64];
  logic       pre_we = 1'b0;
  logic [5:0] pre_addr = '0;
  logic [3:0] pre_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 4'h0;
      tbl_rdata <= 4'h0;
    end else begin
      if (tbl_we) mem[tbl_addr] <= tbl_wdata;
      else if (pre_we) mem[pre_addr] <= pre_data;
      if (tbl_rd) tbl_rdata <= mem[tbl_addr];
    end
  end
  assign prot_present = req_present[prot_gpn];
  assign prot_code    = req_code[prot_gpn];

  page_assign_walker #(.GPN_W(GPN_W), .MPN_W(MPN_W), .IDX_W(IDX_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_remap_i(cmd_remap), .cmd_ready_o(cmd_ready),
    .map_valid_i(map_valid), .map_ready_o(map_ready), .map_gpn_i(map_gpn),
    .map_mpn_i(map_mpn), .map_kind_i(map_kind), .map_last_i(map_last),
    .map_rewind_o(map_rewind), .prot_gpn_o(prot_gpn), .prot_present_i(prot_present),
    .prot_code_i(prot_code), .tbl_rd_o(tbl_rd), .tbl_we_o(tbl_we),
    .tbl_addr_o(tbl_addr), .tbl_wdata_o(tbl_wdata), .tbl_rdata_i(tbl_rdata),
    .done_o(done), .err_o(err), .err_cause_o(err_cause), .err_idx_o(err_idx),
    .flush_o(flush)
  );

  int checks = 0, errors = 0;
  int s_gpn [16];
  int s_mpn [16];
  int s_kind [16];
  int r_err, r_cause, r_idx, r_flush, r_rew;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int i, input int g, input int m, input int k);
    s_gpn[i] = g; s_mpn[i] = m; s_kind[i] = k;
  endtask

  task automatic preload(input int a, input int d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a[5:0]; pre_data = d[3:0];
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic run_cmd(input logic remap, input int n);
    int pos = 0, cyc = 0;
    bit got = 0, hs;
    r_rew = 0;
    @(negedge clk);
    chk("R8 ready idle", int'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_remap = remap;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8 ready busy", int'(cmd_ready), 0);
    while (!got && cyc < 2000) begin
      if (done) begin
        got = 1;
        r_err = int'(err); r_cause = int'(err_cause);
        r_idx = int'(err_idx); r_flush = int'(flush);
      end else begin
        if (map_rewind) begin pos = 0; r_rew++; end
        map_valid = (pos < n);
        map_gpn   = s_gpn[pos % 16][GPN_W-1:0];
        map_mpn   = s_mpn[pos % 16][MPN_W-1:0];
        map_kind  = s_kind[pos % 16][1:0];
        map_last  = (pos == n - 1);
        hs = map_valid && map_ready;
        @(negedge clk);
        if (hs) pos++;
        cyc++;
      end
    end
    map_valid = 1'b0;
    if (!got) begin
      errors++;
      $display("FAIL R8 watchdog: done never seen actual=0 expected=1");
    end
    @(negedge clk);
    chk("R8 done single pulse", int'(done), 0);
  endtask

  task automatic t_reset;
    chk("R10 cmd_ready", int'(cmd_ready), 1);
    chk("R10 done", int'(done), 0);
    chk("R10 map_ready", int'(map_ready), 0);
    chk("R10 rewind", int'(map_rewind), 0);
    chk("R10 tbl_we", int'(tbl_we), 0);
  endtask

  task automatic t_launch_codes;
    put(0, 1, 10, 0); put(1, 2, 11, 0); put(2, 3, 12, 0); put(3, 5, 13, 0); put(4, 4, 14, 0);
    run_cmd(1'b0, 5);
    chk("R2 err", r_err, 0);
    chk("R2 code0", int'(mem[10]), 12);
    chk("R2 code1", int'(mem[11]), 13);
    chk("R2 code2", int'(mem[12]), 14);
    chk("R3 absent", int'(mem[13]), 15);
    chk("R2 code3", int'(mem[14]), 15);
    chk("R9 flush", r_flush, 1);
    chk("R5 no rewind", r_rew, 0);
  endtask

  task automatic t_table_kind;
    put(0, 0, 20, 1); put(1, 1, 21, 0);
    run_cmd(1'b0, 2);
    chk("R3 table kind", int'(mem[20]), 15);
    chk("R2 second", int'(mem[21]), 12);
  endtask

  task automatic t_conflict_mid;
    put(0, 1, 30, 0); put(1, 2, 31, 0); put(2, 3, 11, 0); put(3, 4, 32, 0);
    run_cmd(1'b0, 4);
    chk("R4 err", r_err, 1);
    chk("R1 cause", r_cause, 0);
    chk("R4 idx", r_idx, 2);
    chk("R5 rewinds", r_rew, 1);
    chk("R4 undo 30", int'(mem[30]), 0);
    chk("R4 undo 31", int'(mem[31]), 0);
    chk("R1 owner kept", int'(mem[11]), 13);
    chk("R4 tail untouched", int'(mem[32]), 0);
  endtask

  task automatic t_conflict_first;
    put(0, 1, 12, 0); put(1, 2, 33, 0);
    run_cmd(1'b0, 2);
    chk("R5 err", r_err, 1);
    chk("R5 idx0", r_idx, 0);
    chk("R5 no rewind", r_rew, 0);
    chk("R9 no flush", r_flush, 0);
    chk("R4 tail", int'(mem[33]), 0);
    chk("R1 owner kept", int'(mem[12]), 14);
  endtask

  task automatic t_duplicate;
    put(0, 1, 40, 0); put(1, 2, 41, 0); put(2, 3, 40, 0);
    run_cmd(1'b0, 3);
    chk("R4 dup idx", r_idx, 2);
    chk("R4 dup 40", int'(mem[40]), 0);
    chk("R4 dup 41", int'(mem[41]), 0);
  endtask

  task automatic t_free_pattern;
    preload(50, 3); preload(51, 4);
    put(0, 2, 50, 0);
    run_cmd(1'b0, 1);
    chk("R1 00xx free", r_err, 0);
    chk("R1 00xx claimed", int'(mem[50]), 13);
    put(0, 1, 51, 0);
    run_cmd(1'b0, 1);
    chk("R1 01xx owned", r_err, 1);
    chk("R1 01xx kept", int'(mem[51]), 4);
  endtask

  task automatic t_bad_kind;
    put(0, 1, 52, 0); put(1, 1, 53, 2);
    run_cmd(1'b0, 2);
    chk("R7 release in launch", r_err, 1);
    chk("R7 cause", r_cause, 1);
    chk("R7 idx", r_idx, 1);
    chk("R7 undo", int'(mem[52]), 0);
    put(0, 1, 54, 3);
    run_cmd(1'b1, 1);
    chk("R7 reserved cause", r_cause, 1);
    chk("R7 reserved untouched", int'(mem[54]), 0);
  endtask

  task automatic t_remap_ok;
    put(0, 1, 60, 0); put(1, 0, 61, 1); put(2, 0, 20, 2); put(3, 0, 21, 2);
    run_cmd(1'b1, 4);
    chk("R6 err", r_err, 0);
    chk("R6 rewind pass", r_rew, 1);
    chk("R6 new", int'(mem[60]), 12);
    chk("R6 map page", int'(mem[61]), 15);
    chk("R6 rel 20", int'(mem[20]), 0);
    chk("R6 rel 21", int'(mem[21]), 0);
  endtask

  task automatic t_remap_fail;
    put(0, 0, 10, 2); put(1, 2, 62, 0); put(2, 3, 14, 0);
    run_cmd(1'b1, 3);
    chk("R6 fail err", r_err, 1);
    chk("R6 fail idx", r_idx, 2);
    chk("R6 no release", int'(mem[10]), 12);
    chk("R6 undo 62", int'(mem[62]), 0);
    chk("R6 owner kept", int'(mem[14]), 15);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin req_present[i] = 1'b0; req_code[i] = 2'd0; end
    req_present[1] = 1'b1; req_code[1] = 2'd0;
    req_present[2] = 1'b1; req_code[2] = 2'd1;
    req_present[3] = 1'b1; req_code[3] = 2'd2;
    req_present[4] = 1'b1; req_code[4] = 2'd3;
    for (int i = 0; i < 16; i++) begin s_gpn[i] = 0; s_mpn[i] = 0; s_kind[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_launch_codes();
    t_table_kind();
    t_conflict_mid();
    t_conflict_first();
    t_duplicate();
    t_free_pattern();
    t_bad_kind();
    t_remap_ok();
    t_remap_fail();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 global watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule